// File: doc/BRIEF.md
# Register Rename Table with Branch Checkpoints

This block sits in the rename stage of an out-of-order core. It keeps one mapping entry for each architectural register. An entry is either empty, which means the committed architectural register holds the current value, or it names the physical register that the newest in-flight writer will fill. Up to two instructions arrive per cycle in program order as one group. Each instruction that writes a register takes a physical tag from a free bitmap. Each source operand is answered with a physical tag or with an architectural marker. A source of the second instruction that names the first instruction's destination is bypassed to the tag allocated in the same cycle.

A group is accepted whole or not at all. When the free bitmap cannot cover every writer in the group, the group stalls. A group that ends in a predicted branch can save a full snapshot of the mapping and of the free bitmap into one of several checkpoint slots; the caller picks the slot. A misprediction restores a slot in one cycle. This discards every mapping made after the branch and returns the physical registers allocated after it to the free bitmap.

The commit port retires one writer per cycle. It frees that physical register, and it clears the mapping entry only if the entry still names the committing tag. The same clearing is applied to every stored snapshot, so a later restore never brings back a freed tag.

Top module: `rename_ckpt_table`

## Requirements
- R1: After reset every mapping entry is empty and all physical tags are free. Every source reports the architectural marker (`rsp_src_arch_o` bit = 1), and the first two writers receive tags 0 and 1.
- R2: Writers take the lowest free tags, and slot 0 takes the lower of the two when both slots write. A slot that is invalid or does not write consumes no tag. Slot 1's destination tag is on bits [2*PW-1:PW] of `rsp_dst_tag_o`.
- R3: A source resolves to the tag of the newest older writer of its register, with the marker bit at 0. With no such writer in flight it reports the marker at 1. Source g, with g = 2*slot + operand, occupies `rsp_src_tag_o[g*PW +: PW]` and `rsp_src_arch_o[g]`.
- R4: A slot 1 source that names slot 0's destination, when slot 0 is valid and writes, reports slot 0's newly allocated tag with the marker at 0.
- R5: When both slots of an accepted group write the same register, slot 1's tag becomes the mapping.
- R6: `ren_ready_o` is 0 when the free tags are fewer than the writers in the group. A group that is not accepted changes neither the mappings nor the free bitmap.
- R7: A commit frees its tag, and the tag can be allocated from the next cycle on. The mapping entry is cleared only if it still names the committing tag; otherwise it keeps its newer tag.
- R8: The sources of a group resolve against the mapping after a commit in the same cycle has been applied. A group's new mappings override the clearing done by a commit in the same cycle.
- R9: With `ckpt_save_i` set on an accepted group, the slot stores the mapping after that group. `recover_i` restores the slot in the next cycle and holds `ren_ready_o` at 0 in its own cycle.
- R10: A restore frees every tag that was allocated after the save. It keeps as free, and as unmapped, every tag committed after the save.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ren_valid_i | input | 2 | Slot valid, bit 0 is the older slot |
| ren_we_i | input | 2 | Slot writes a destination register |
| ren_dst_i | input | 2*AW | Destination architectural index per slot |
| ren_src_i | input | 4*AW | Source architectural indices, entry 2*slot+operand |
| ren_ready_o | output | 1 | Group accepted this cycle |
| rsp_src_tag_o | output | 4*PW | Physical tag per source |
| rsp_src_arch_o | output | 4 | Source reads the architectural register |
| rsp_dst_tag_o | output | 2*PW | Allocated tag per slot |
| ckpt_save_i | input | 1 | Save a snapshot after this group |
| ckpt_save_idx_i | input | CW | Snapshot slot to write |
| recover_i | input | 1 | Restore from a snapshot |
| recover_idx_i | input | CW | Snapshot slot to restore |
| cmt_valid_i | input | 1 | Commit one writer |
| cmt_arch_i | input | AW | Committed architectural register |
| cmt_tag_i | input | PW | Committed physical tag |

## Verification
A commit and a rename can fall in the same cycle, and so can a commit and a recovery. The bench provokes the first case in three ways. It commits a tag that a newer writer has already displaced. It commits a live mapping while the same group reads that register and also writes it again. It checks that a tag freed in that cycle is not handed out until the next one. For the second case, a register is committed between a checkpoint save and its restore. The bench then checks that the restored table reads that register as architectural, and that the restored free list hands the committed tag out first, ahead of the tags allocated after the branch.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int unsigned RN_SLOTS = 2;
  localparam int unsigned RN_SRCS  = 2;
  localparam int unsigned RN_DEF_ARCH = 8;
  localparam int unsigned RN_DEF_PHYS = 16;
  localparam int unsigned RN_DEF_CKPT = 4;
endpackage

// File: rtl/rn_alloc.sv
module rn_alloc #(
  parameter int unsigned NUM_PHYS = 16,
  localparam int unsigned PW = $clog2(NUM_PHYS)
) (
  input  logic [NUM_PHYS-1:0] free_i,
  output logic [PW-1:0]       tag0_o,
  output logic                ok0_o,
  output logic [PW-1:0]       tag1_o,
  output logic                ok1_o
);
  logic [NUM_PHYS-1:0] rest;

  always_comb begin
    tag0_o = '0;
    ok0_o  = 1'b0;
    for (int i = NUM_PHYS-1; i >= 0; i--) begin
      if (free_i[i]) begin
        tag0_o = PW'(i);
        ok0_o  = 1'b1;
      end
    end
  end

  always_comb begin
    rest = free_i;
    if (ok0_o) rest[tag0_o] = 1'b0;
  end

  always_comb begin
    tag1_o = '0;
    ok1_o  = 1'b0;
    for (int i = NUM_PHYS-1; i >= 0; i--) begin
      if (rest[i]) begin
        tag1_o = PW'(i);
        ok1_o  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rn_lookup.sv
module rn_lookup #(
  parameter int unsigned NUM_ARCH = 8,
  parameter int unsigned NUM_PHYS = 16,
  localparam int unsigned AW = $clog2(NUM_ARCH),
  localparam int unsigned PW = $clog2(NUM_PHYS)
) (
  input  logic [NUM_ARCH-1:0]         map_vld_i,
  input  logic [NUM_ARCH-1:0][PW-1:0] map_tag_i,
  input  logic [AW-1:0]               src_i,
  input  logic                        byp_en_i,
  input  logic [AW-1:0]               byp_dst_i,
  input  logic [PW-1:0]               byp_tag_i,
  output logic [PW-1:0]               tag_o,
  output logic                        arch_o
);
  logic hit;
  assign hit = byp_en_i && (byp_dst_i == src_i);

  always_comb begin
    if (hit) begin
      tag_o  = byp_tag_i;
      arch_o = 1'b0;
    end else begin
      tag_o  = map_tag_i[src_i];
      arch_o = !map_vld_i[src_i];
    end
  end
endmodule

// File: rtl/rn_ckpt_store.sv
module rn_ckpt_store #(
  parameter int unsigned NUM_ARCH = 8,
  parameter int unsigned NUM_PHYS = 16,
  parameter int unsigned NUM_CKPT = 4,
  localparam int unsigned AW = $clog2(NUM_ARCH),
  localparam int unsigned PW = $clog2(NUM_PHYS),
  localparam int unsigned CW = (NUM_CKPT > 1) ? $clog2(NUM_CKPT) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        save_i,
  input  logic [CW-1:0]               save_idx_i,
  input  logic [NUM_ARCH-1:0]         save_vld_i,
  input  logic [NUM_ARCH-1:0][PW-1:0] save_tag_i,
  input  logic [NUM_PHYS-1:0]         save_free_i,
  input  logic                        cmt_valid_i,
  input  logic [AW-1:0]               cmt_arch_i,
  input  logic [PW-1:0]               cmt_tag_i,
  input  logic [CW-1:0]               rd_idx_i,
  output logic [NUM_ARCH-1:0]         rd_vld_o,
  output logic [NUM_ARCH-1:0][PW-1:0] rd_tag_o,
  output logic [NUM_PHYS-1:0]         rd_free_o
);
  logic [NUM_CKPT-1:0][NUM_ARCH-1:0]         ck_vld_q;
  logic [NUM_CKPT-1:0][NUM_ARCH-1:0][PW-1:0] ck_tag_q;
  logic [NUM_CKPT-1:0][NUM_PHYS-1:0]         ck_free_q;

  for (genvar c = 0; c < NUM_CKPT; c++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ck_vld_q[c]  <= '0;
        ck_tag_q[c]  <= '0;
        ck_free_q[c] <= '1;
      end else if (save_i && (save_idx_i == CW'(c))) begin
        ck_vld_q[c]  <= save_vld_i;
        ck_tag_q[c]  <= save_tag_i;
        ck_free_q[c] <= save_free_i;
      end else if (cmt_valid_i) begin
        // older writer retired while the snapshot is held
        ck_free_q[c][cmt_tag_i] <= 1'b1;
        if (ck_vld_q[c][cmt_arch_i] && ck_tag_q[c][cmt_arch_i] == cmt_tag_i)
          ck_vld_q[c][cmt_arch_i] <= 1'b0;
      end
    end
  end

  assign rd_vld_o  = ck_vld_q[rd_idx_i];
  assign rd_tag_o  = ck_tag_q[rd_idx_i];
  assign rd_free_o = ck_free_q[rd_idx_i];
endmodule

// File: rtl/rename_ckpt_table.sv
module rename_ckpt_table
  import rn_pkg::*;
#(
  parameter int unsigned NUM_ARCH = RN_DEF_ARCH,
  parameter int unsigned NUM_PHYS = RN_DEF_PHYS,
  parameter int unsigned NUM_CKPT = RN_DEF_CKPT,
  localparam int unsigned AW = $clog2(NUM_ARCH),
  localparam int unsigned PW = $clog2(NUM_PHYS),
  localparam int unsigned CW = (NUM_CKPT > 1) ? $clog2(NUM_CKPT) : 1,
  localparam int unsigned NS = RN_SLOTS * RN_SRCS
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [RN_SLOTS-1:0]    ren_valid_i,
  input  logic [RN_SLOTS-1:0]    ren_we_i,
  input  logic [RN_SLOTS*AW-1:0] ren_dst_i,
  input  logic [NS*AW-1:0]       ren_src_i,
  output logic                   ren_ready_o,
  output logic [NS*PW-1:0]       rsp_src_tag_o,
  output logic [NS-1:0]          rsp_src_arch_o,
  output logic [RN_SLOTS*PW-1:0] rsp_dst_tag_o,
  input  logic                   ckpt_save_i,
  input  logic [CW-1:0]          ckpt_save_idx_i,
  input  logic                   recover_i,
  input  logic [CW-1:0]          recover_idx_i,
  input  logic                   cmt_valid_i,
  input  logic [AW-1:0]          cmt_arch_i,
  input  logic [PW-1:0]          cmt_tag_i
);
  logic [NUM_ARCH-1:0]         map_vld_q, map_vld_d;
  logic [NUM_ARCH-1:0][PW-1:0] map_tag_q, map_tag_d;
  logic [NUM_PHYS-1:0]         free_q, free_d;

  logic [NUM_ARCH-1:0]         ck_vld, base_vld, cm_vld;
  logic [NUM_ARCH-1:0][PW-1:0] ck_tag, base_tag;
  logic [NUM_PHYS-1:0]         ck_free, base_free, cm_free;

  logic [PW-1:0] a_tag0, a_tag1, dtag0, dtag1;
  logic          a_ok0, a_ok1, wr0, wr1, room, fire;
  logic [1:0]    need;
  logic [AW-1:0] dst0, dst1;

  assign dst0 = ren_dst_i[0 +: AW];
  assign dst1 = ren_dst_i[AW +: AW];
  assign wr0  = ren_valid_i[0] && ren_we_i[0];
  assign wr1  = ren_valid_i[1] && ren_we_i[1];
  assign need = 2'(wr0) + 2'(wr1);

  rn_alloc #(.NUM_PHYS(NUM_PHYS)) u_alloc (
    .free_i (free_q),
    .tag0_o (a_tag0),
    .ok0_o  (a_ok0),
    .tag1_o (a_tag1),
    .ok1_o  (a_ok1)
  );

  always_comb begin
    unique case (need)
      2'd0:    room = 1'b1;
      2'd1:    room = a_ok0;
      default: room = a_ok1;
    endcase
  end

  assign ren_ready_o = !recover_i && room;
  assign fire        = ren_ready_o;
  assign dtag0       = a_tag0;
  assign dtag1       = wr0 ? a_tag1 : a_tag0;
  assign rsp_dst_tag_o = {dtag1, dtag0};

  // restore source, then commit fix-up, then the group's writes
  assign base_vld  = recover_i ? ck_vld  : map_vld_q;
  assign base_tag  = recover_i ? ck_tag  : map_tag_q;
  assign base_free = recover_i ? ck_free : free_q;

  always_comb begin
    cm_vld  = base_vld;
    cm_free = base_free;
    if (cmt_valid_i) begin
      cm_free[cmt_tag_i] = 1'b1;
      if (base_vld[cmt_arch_i] && base_tag[cmt_arch_i] == cmt_tag_i)
        cm_vld[cmt_arch_i] = 1'b0;
    end
  end

  always_comb begin
    map_vld_d = cm_vld;
    map_tag_d = base_tag;
    free_d    = cm_free;
    if (fire && wr0) begin
      map_vld_d[dst0] = 1'b1;
      map_tag_d[dst0] = dtag0;
      free_d[dtag0]   = 1'b0;
    end
    if (fire && wr1) begin
      map_vld_d[dst1] = 1'b1;
      map_tag_d[dst1] = dtag1;
      free_d[dtag1]   = 1'b0;
    end
  end

  for (genvar g = 0; g < NS; g++) begin : g_src
    localparam int unsigned SLOT = g / RN_SRCS;
    logic byp_en;
    if (SLOT == 0) begin : g_old
      assign byp_en = 1'b0;
    end else begin : g_young
      assign byp_en = wr0;
    end
    rn_lookup #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_lkp (
      .map_vld_i (cm_vld),
      .map_tag_i (map_tag_q),
      .src_i     (ren_src_i[g*AW +: AW]),
      .byp_en_i  (byp_en),
      .byp_dst_i (dst0),
      .byp_tag_i (dtag0),
      .tag_o     (rsp_src_tag_o[g*PW +: PW]),
      .arch_o    (rsp_src_arch_o[g])
    );
  end

  rn_ckpt_store #(
    .NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .NUM_CKPT(NUM_CKPT)
  ) u_ckpt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .save_i      (ckpt_save_i && fire),
    .save_idx_i  (ckpt_save_idx_i),
    .save_vld_i  (map_vld_d),
    .save_tag_i  (map_tag_d),
    .save_free_i (free_d),
    .cmt_valid_i (cmt_valid_i),
    .cmt_arch_i  (cmt_arch_i),
    .cmt_tag_i   (cmt_tag_i),
    .rd_idx_i    (recover_idx_i),
    .rd_vld_o    (ck_vld),
    .rd_tag_o    (ck_tag),
    .rd_free_o   (ck_free)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_vld_q <= '0;
      map_tag_q <= '0;
      free_q    <= '1;
    end else begin
      map_vld_q <= map_vld_d;
      map_tag_q <= map_tag_d;
      free_q    <= free_d;
    end
  end
endmodule

// File: rtl/rename_ckpt_table_chk.sv
module rename_ckpt_table_chk #(
  parameter int unsigned NUM_ARCH = 8,
  parameter int unsigned NUM_PHYS = 16,
  localparam int unsigned AW = $clog2(NUM_ARCH),
  localparam int unsigned PW = $clog2(NUM_PHYS)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [1:0]          ren_valid_i,
  input logic [1:0]          ren_we_i,
  input logic [2*AW-1:0]     ren_dst_i,
  input logic [4*AW-1:0]     ren_src_i,
  input logic                ren_ready_o,
  input logic [4*PW-1:0]     rsp_src_tag_o,
  input logic [3:0]          rsp_src_arch_o,
  input logic [2*PW-1:0]     rsp_dst_tag_o,
  input logic                recover_i,
  input logic                cmt_valid_i,
  input logic [PW-1:0]       cmt_tag_i,
  input logic [NUM_PHYS-1:0] free_q
);
  logic both_wr;
  assign both_wr = &(ren_valid_i & ren_we_i);

  // R2
  alloc_distinct_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_ready_o && both_wr) |-> (rsp_dst_tag_o[PW-1:0] != rsp_dst_tag_o[2*PW-1:PW]));

  // R2
  alloc_from_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_ready_o && ren_valid_i[0] && ren_we_i[0]) |-> free_q[rsp_dst_tag_o[PW-1:0]]);

  // R4
  same_group_byp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_valid_i[0] && ren_we_i[0] && ren_src_i[2*AW +: AW] == ren_dst_i[0 +: AW])
      |-> (!rsp_src_arch_o[2] && rsp_src_tag_o[2*PW +: PW] == rsp_dst_tag_o[PW-1:0]));

  // R6
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ren_ready_o && !cmt_valid_i && !recover_i) |=> $stable(free_q));

  // R7
  commit_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmt_valid_i |=> free_q[$past(cmt_tag_i)]);

  // R9
  recover_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recover_i |-> !ren_ready_o);
endmodule

bind rename_ckpt_table rename_ckpt_table_chk #(
  .NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ren_valid_i    (ren_valid_i),
  .ren_we_i       (ren_we_i),
  .ren_dst_i      (ren_dst_i),
  .ren_src_i      (ren_src_i),
  .ren_ready_o    (ren_ready_o),
  .rsp_src_tag_o  (rsp_src_tag_o),
  .rsp_src_arch_o (rsp_src_arch_o),
  .rsp_dst_tag_o  (rsp_dst_tag_o),
  .recover_i      (recover_i),
  .cmt_valid_i    (cmt_valid_i),
  .cmt_tag_i      (cmt_tag_i),
  .free_q         (free_q)
);

// File: tb/rename_ckpt_table_test.sv
module rename_ckpt_table_test;
  localparam int AW = 3;
  localparam int PW = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  ren_valid, ren_we;
  logic [5:0]  ren_dst;
  logic [11:0] ren_src;
  logic        ren_ready;
  logic [15:0] src_tag;
  logic [3:0]  src_arch;
  logic [7:0]  dst_tag;
  logic        ck_save, recover, cmt_valid;
  logic [1:0]  ck_idx, rec_idx;
  logic [2:0]  cmt_arch;
  logic [3:0]  cmt_tag;

  typedef struct {
    logic        rdy;
    logic [3:0]  arch;
    logic [3:0]  msk_src;
    logic [15:0] src;
    logic [1:0]  msk_dst;
    logic [7:0]  dst;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 1'b0;

  always #5 clk = ~clk;

  rename_ckpt_table uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .ren_valid_i(ren_valid), .ren_we_i(ren_we), .ren_dst_i(ren_dst), .ren_src_i(ren_src),
    .ren_ready_o(ren_ready), .rsp_src_tag_o(src_tag), .rsp_src_arch_o(src_arch),
    .rsp_dst_tag_o(dst_tag), .ckpt_save_i(ck_save), .ckpt_save_idx_i(ck_idx),
    .recover_i(recover), .recover_idx_i(rec_idx),
    .cmt_valid_i(cmt_valid), .cmt_arch_i(cmt_arch), .cmt_tag_i(cmt_tag)
  );

  task automatic idle();
    ren_valid = '0; ren_we = '0; ren_dst = '0; ren_src = '0;
    ck_save = 1'b0; ck_idx = '0; recover = 1'b0; rec_idx = '0;
    cmt_valid = 1'b0; cmt_arch = '0; cmt_tag = '0;
  endtask

  task automatic slot(int s, bit v, bit we, int d, int a, int b);
    ren_valid[s] = v;
    ren_we[s]    = we;
    ren_dst[s*AW +: AW]       = AW'(d);
    ren_src[(2*s)*AW +: AW]   = AW'(a);
    ren_src[(2*s+1)*AW +: AW] = AW'(b);
  endtask

  task automatic commit(int a, int t);
    cmt_valid = 1'b1; cmt_arch = AW'(a); cmt_tag = PW'(t);
  endtask

  // driver: queue the expectation, hold inputs through the next rising edge
  task automatic apply(logic rdy, logic [3:0] arch, logic [3:0] ms, logic [15:0] src,
                       logic [1:0] md, logic [7:0] dst, string req);
    exp_t e;
    e.rdy = rdy; e.arch = arch; e.msk_src = ms; e.src = src;
    e.msk_dst = md; e.dst = dst; e.req = req;
    exp_q.push_back(e);
    @(posedge clk);
    #1;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        bit bad;
        e = exp_q.pop_front();
        bad = (ren_ready !== e.rdy);
        for (int g = 0; g < 4; g++) begin
          if (e.msk_src[g]) begin
            if (src_arch[g] !== e.arch[g]) bad = 1'b1;
            else if (!e.arch[g] && src_tag[g*PW +: PW] !== e.src[g*PW +: PW]) bad = 1'b1;
          end
        end
        for (int s = 0; s < 2; s++)
          if (e.msk_dst[s] && dst_tag[s*PW +: PW] !== e.dst[s*PW +: PW]) bad = 1'b1;
        n_chk++;
        if (bad) begin
          n_err++;
          $display("FAIL %s: got rdy=%b arch=%b src=%h dst=%h, expected rdy=%b arch=%b src=%h dst=%h",
                   e.req, ren_ready, src_arch, src_tag, dst_tag, e.rdy, e.arch, e.src, e.dst);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (2) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(posedge clk); #1;

    // R1 R3: empty table answers architectural
    idle(); slot(0,1,0,0,1,2); slot(1,1,0,0,3,4);
    apply(1, 4'b1111, 4'b1111, 16'h0000, 2'b00, 8'h00, "R1");
    // R1 R2 R4: tags 0,1; slot1 r1 bypassed to tag 0
    idle(); slot(0,1,1,1,2,3); slot(1,1,1,2,1,5);
    apply(1, 4'b1011, 4'b1111, 16'h0000, 2'b11, 8'h10, "R4");
    // R3 R4: r4 written twice in group
    idle(); slot(0,1,1,4,1,2); slot(1,1,1,4,4,6);
    apply(1, 4'b1000, 4'b1111, 16'h0210, 2'b11, 8'h32, "R4");
    // R5: r4 maps to slot1 tag 3; R2 non-writer consumes nothing
    idle(); slot(0,1,0,0,4,2); slot(1,1,1,5,1,7);
    apply(1, 4'b1000, 4'b1111, 16'h0013, 2'b10, 8'h40, "R5");
    // R7: stale commit of tag 2 keeps r4->3; freed tag not reused this cycle
    idle(); commit(4,2); slot(0,1,0,0,4,4); slot(1,1,1,6,6,6);
    apply(1, 4'b1100, 4'b1111, 16'h0033, 2'b10, 8'h50, "R7");
    // R7: tag 2 allocatable now
    idle(); slot(0,1,1,7,4,0);
    apply(1, 4'b0010, 4'b0011, 16'h0003, 2'b01, 8'h02, "R7");
    // R8: commit r1/tag0 with same-cycle read and rewrite of r1
    idle(); commit(1,0); slot(0,1,0,0,1,1); slot(1,1,1,1,1,2);
    apply(1, 4'b0111, 4'b1111, 16'h1000, 2'b10, 8'h60, "R8");
    // R8 R9: r1 now tag 6; save checkpoint 1 after this group
    idle(); ck_save = 1'b1; ck_idx = 2'd1; slot(0,1,0,0,1,5); slot(1,1,1,3,3,7);
    apply(1, 4'b0100, 4'b1111, 16'h2046, 2'b10, 8'h00, "R9");
    // speculative group; commit r2/tag1 read in same cycle
    idle(); commit(2,1); slot(0,1,1,1,3,2); slot(1,1,1,5,1,5);
    apply(1, 4'b0010, 4'b1111, 16'h4700, 2'b11, 8'h87, "R8");
    // R9: recovery cycle refuses the group
    idle(); recover = 1'b1; rec_idx = 2'd1; slot(0,1,1,2,0,0); slot(1,1,1,3,0,0);
    apply(0, 4'b0000, 4'b0000, 16'h0000, 2'b00, 8'h00, "R9");
    // R9 R10: pre-branch mapping back, r2 stays architectural, tag 1 free
    idle(); slot(0,1,0,0,1,5); slot(1,1,1,2,2,3);
    apply(1, 4'b0100, 4'b1111, 16'h0046, 2'b10, 8'h10, "R10");
    // R10: tags 7,8 from the flushed path are free again
    idle(); slot(0,1,1,0,1,1); slot(1,1,1,3,0,3);
    apply(1, 4'b0000, 4'b1111, 16'h0766, 2'b11, 8'h87, "R10");
    // drain to one free tag
    idle(); slot(0,1,1,4,0,0); slot(1,1,1,5,0,0);
    apply(1, 4'b0000, 4'b0000, 16'h0000, 2'b11, 8'hA9, "R2");
    idle(); slot(0,1,1,4,0,0); slot(1,1,1,5,0,0);
    apply(1, 4'b0000, 4'b0000, 16'h0000, 2'b11, 8'hCB, "R2");
    idle(); slot(0,1,1,4,0,0); slot(1,1,1,5,0,0);
    apply(1, 4'b0000, 4'b0000, 16'h0000, 2'b11, 8'hED, "R2");
    // R6: two writers, one free tag
    idle(); slot(0,1,1,6,4,5); slot(1,1,1,7,4,5);
    apply(0, 4'b0000, 4'b0000, 16'h0000, 2'b00, 8'h00, "R6");
    // R6: stalled group left r6/r7 untouched
    idle(); slot(0,1,1,6,6,7);
    apply(1, 4'b0000, 4'b0011, 16'h0025, 2'b01, 8'h0F, "R6");
    // R7: commit matching r6/tag15
    idle(); commit(6,15);
    apply(1, 4'b0000, 4'b0000, 16'h0000, 2'b00, 8'h00, "R7");
    // R7: r6 reverted, tag 15 reusable
    idle(); slot(0,1,0,0,6,7); slot(1,1,1,1,6,1);
    apply(1, 4'b0101, 4'b1111, 16'h6020, 2'b10, 8'hF0, "R7");

    idle();
    @(posedge clk); #1;
    @(negedge clk); #4;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule